// File: doc/BRIEF.md
# I2C Multimaster Byte Engine

This block is the master half of an I2C controller that shares the bus with other masters. A processor-side command port accepts four operations: begin a transfer, send a byte, receive a byte, and end the transfer. The controller drives both bus lines through open-drain pull-down enables. It reads the resolved line levels back, so it can detect bus traffic, slaves that stretch the clock, and lost arbitration.

The controller comes out of reset as a passive slave. A start operation on an idle bus promotes it to master, and it keeps SCL low between operations. It hands the bus back when it finishes a stop sequence. It also hands the bus back at once when another master wins arbitration. Status flags report the end of each byte, a missing acknowledge, lost arbitration, the direction of the last byte and bus occupancy. An optional interrupt follows these flags. The SCL low and high half-periods are counts of system clocks, with one pair for standard mode and one pair for fast mode. A 7-bit or 10-bit address is sent as one or two ordinary write bytes.

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset both line enables are low, the controller is in slave mode, every flag and the interrupt are low, `rx_data` is zero and `cmd_ready` is high.
- R2: `cmd_op`=0 (start) is taken only in slave mode while the bus is not busy. It pulls SDA low while SCL is released, then enters master mode and holds SCL low. In any other case it is ignored.
- R3: `cmd_op`=1 (write), 2 (read) and 3 (stop) are ignored in slave mode. Any command is ignored while `cmd_ready` is low.
- R4: A write sends `cmd_data` MSB first over 8 SCL cycles. The controller releases SDA for the 9th cycle and samples it. A high sample sets `st_ack_fail`. The write sets `st_tx` to 1.
- R5: A read shifts 8 bits MSB first into `rx_data`. In the 9th cycle the controller pulls SDA low if `cmd_data[0]`=1 and leaves it released if `cmd_data[0]`=0. The read sets `st_tx` to 0.
- R6: Within a byte, each SCL low half lasts LOW and each high half lasts HIGH system clocks. The standard pair applies when `cfg_fast`=0 and the fast pair when `cfg_fast`=1.
- R7: When a device holds SCL low, the high-half count starts only once SCL is seen high. The byte then completes correctly.
- R8: During the 8 data bits of a write, if the controller releases SDA but sees it low while SCL is high, it releases both lines, drops to slave mode and sets `st_arb_lost`. A bit the controller drives low never loses.
- R9: A stop pulls SDA low with SCL low, releases SCL, then releases SDA while SCL is high. After that the controller is in slave mode with both lines released.
- R10: `st_busy` sets on any start condition seen on the bus and clears on any stop condition seen on the bus, whichever master produced it.
- R11: `st_eob` sets after the 9th cycle of each byte. It clears on `status_rd` or when a write is taken. `st_ack_fail` and `st_arb_lost` clear on `status_rd`.
- R12: `irq` is high one cycle after any of `st_eob`, `st_ack_fail` or `st_arb_lost` is high while `cfg_irq_en` is 1. It is low while `cfg_irq_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_data | input | 8 | Byte to write; bit 0 is the acknowledge choice for a read |
| cmd_ready | output | 1 | Controller can take a command |
| cfg_fast | input | 1 | Selects the fast-mode half-periods |
| cfg_irq_en | input | 1 | Interrupt enable |
| status_rd | input | 1 | Status read strobe; clears the sticky flags |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| rx_data | output | 8 | Last byte shifted across the bus |
| st_master | output | 1 | Master mode |
| st_busy | output | 1 | Bus busy |
| st_tx | output | 1 | Last byte was a write |
| st_eob | output | 1 | End of byte |
| st_ack_fail | output | 1 | Acknowledge missing after a write |
| st_arb_lost | output | 1 | Arbitration lost |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the controller with half-periods of 12 and 10 clocks for standard mode and 5 and 4 clocks for fast mode. At these values a byte takes a few hundred cycles, so dozens of random bytes fit in the run. The two modes give different phase lengths, and the bench measures each low and high run on the bus exactly. A 25-cycle clock stretch is longer than any phase, so a high-phase count that started too early would show up as a wrong run length.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } i2cm_op_e;

  typedef enum logic [2:0] {
    ST_SLAVE,
    ST_BEGIN,
    ST_HOLD,
    ST_BLO,
    ST_BHI,
    ST_PLO,
    ST_PHI,
    ST_PREL
  } i2cm_state_e;
endpackage

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          en,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (en && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/i2cm_bus_monitor.sv
module i2cm_bus_monitor (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic busy
);
  logic scl_q, sda_q, start_seen, stop_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_seen = scl_q && scl_i && sda_q && !sda_i;
  assign stop_seen  = scl_q && scl_i && !sda_q && sda_i;

  always_ff @(posedge clk) begin
    if (rst)             busy <= 1'b0;
    else if (start_seen) busy <= 1'b1;
    else if (stop_seen)  busy <= 1'b0;
  end

  // R10: a condition seen on the lines is reflected in the flag next cycle
  p_busy_set_r10: assert property (@(posedge clk) disable iff (rst)
    start_seen |=> busy);
  p_busy_clr_r10: assert property (@(posedge clk) disable iff (rst)
    stop_seen |=> !busy);
endmodule

// File: rtl/i2cm_byte_engine.sv
module i2cm_byte_engine
  import i2cm_pkg::*;
#(
  parameter int LOW_STD   = 250,
  parameter int HIGH_STD  = 250,
  parameter int LOW_FAST  = 63,
  parameter int HIGH_FAST = 62
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  i2cm_op_e   cmd_op,
  input  logic [7:0] cmd_byte,
  input  logic       fast,
  input  logic       bus_busy,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       ready,
  output logic       taken,
  output logic       master,
  output logic       wr,
  output logic [7:0] shreg,
  output logic       done_p,
  output logic       nack_p,
  output logic       arb_p
);
  localparam int MAX_LO = (LOW_STD > LOW_FAST) ? LOW_STD : LOW_FAST;
  localparam int MAX_HI = (HIGH_STD > HIGH_FAST) ? HIGH_STD : HIGH_FAST;
  localparam int MAXC   = (MAX_LO > MAX_HI) ? MAX_LO : MAX_HI;
  localparam int CW     = $clog2(MAXC + 1);

  i2cm_state_e   state, nxt;
  logic [3:0]    bitc;
  logic          ack_drv, last_bit, sda_drv, arb_hit, fin;
  logic          tmr_load, tmr_en, tmr_zero;
  logic [CW-1:0] lo_val, hi_val, tmr_val;

  assign lo_val   = fast ? CW'(LOW_FAST - 1)  : CW'(LOW_STD - 1);
  assign hi_val   = fast ? CW'(HIGH_FAST - 1) : CW'(HIGH_STD - 1);
  assign last_bit = (bitc == 4'd8);
  assign ready    = (state == ST_SLAVE) || (state == ST_HOLD);

  always_comb begin
    taken = 1'b0;
    if (cmd_valid && ready)
      taken = (cmd_op == OP_START) ? (!master && !bus_busy) : master;
    tmr_en  = (state == ST_BHI || state == ST_PHI) ? scl_i : 1'b1;
    fin     = tmr_zero && tmr_en;
    arb_hit = (state == ST_BHI) && wr && !last_bit && !sda_drv && scl_i && !sda_i;
    nxt = state;
    unique case (state)
      ST_SLAVE: if (taken) nxt = ST_BEGIN;
      ST_BEGIN: if (fin) nxt = ST_HOLD;
      ST_HOLD:  if (taken) nxt = (cmd_op == OP_STOP) ? ST_PLO : ST_BLO;
      ST_BLO:   if (fin) nxt = ST_BHI;
      ST_BHI: begin
        if (arb_hit)  nxt = ST_SLAVE;
        else if (fin) nxt = last_bit ? ST_HOLD : ST_BLO;
      end
      ST_PLO:   if (fin) nxt = ST_PHI;
      ST_PHI:   if (fin) nxt = ST_PREL;
      ST_PREL:  if (fin) nxt = ST_SLAVE;
      default:  nxt = ST_SLAVE;
    endcase
    tmr_load = (nxt != state);
    tmr_val  = (nxt == ST_BLO || nxt == ST_PLO) ? lo_val : hi_val;
  end

  always_comb begin
    unique case (state)
      ST_BEGIN, ST_PLO, ST_PHI: sda_drv = 1'b1;
      ST_BLO, ST_BHI:           sda_drv = last_bit ? (!wr && ack_drv) : (wr && !shreg[7]);
      default:                  sda_drv = 1'b0;
    endcase
  end

  assign sda_oe = sda_drv;
  assign scl_oe = (state == ST_HOLD) || (state == ST_BLO) || (state == ST_PLO);

  i2cm_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .en(tmr_en), .zero(tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_SLAVE;
      master  <= 1'b0;
      wr      <= 1'b0;
      ack_drv <= 1'b0;
      bitc    <= 4'd0;
      shreg   <= 8'h00;
      done_p  <= 1'b0;
      nack_p  <= 1'b0;
      arb_p   <= 1'b0;
    end else begin
      state  <= nxt;
      done_p <= 1'b0;
      nack_p <= 1'b0;
      arb_p  <= arb_hit;
      if (taken && cmd_op == OP_WRITE) begin
        shreg <= cmd_byte;
        wr    <= 1'b1;
        bitc  <= 4'd0;
      end
      if (taken && cmd_op == OP_READ) begin
        wr      <= 1'b0;
        ack_drv <= cmd_byte[0];
        bitc    <= 4'd0;
      end
      if (state == ST_BEGIN && fin) master <= 1'b1;
      if (arb_hit || (state == ST_PREL && fin)) master <= 1'b0;
      if (state == ST_BHI && fin && !arb_hit) begin
        if (last_bit) begin
          done_p <= 1'b1;
          nack_p <= wr && sda_i;
        end else begin
          shreg <= {shreg[6:0], sda_i};
          bitc  <= bitc + 4'd1;
        end
      end
    end
  end

  // R2: master mode is entered only from the start sequence
  p_master_on_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(master) |-> $past(state) == ST_BEGIN);
  // R4: the data line does not move while SCL is released within a bit
  p_hi_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BHI && $past(state) == ST_BHI) |-> $stable(sda_oe));
  // R8: a lost bit frees both lines and the master role at once
  p_arb_release_r8: assert property (@(posedge clk) disable iff (rst)
    arb_hit |=> (!scl_oe && !sda_oe && !master));
  // R9: leaving master mode leaves both lines released
  p_demote_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(master) |-> (!scl_oe && !sda_oe));
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int LOW_STD   = 250,
  parameter int HIGH_STD  = 250,
  parameter int LOW_FAST  = 63,
  parameter int HIGH_FAST = 62
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  output logic       cmd_ready,
  input  logic       cfg_fast,
  input  logic       cfg_irq_en,
  input  logic       status_rd,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] rx_data,
  output logic       st_master,
  output logic       st_busy,
  output logic       st_tx,
  output logic       st_eob,
  output logic       st_ack_fail,
  output logic       st_arb_lost,
  output logic       irq
);
  i2cm_op_e op;
  logic     taken, wr, done_p, nack_p, arb_p;

  assign op = i2cm_op_e'(cmd_op);

  i2cm_bus_monitor u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .busy(st_busy)
  );

  i2cm_byte_engine #(
    .LOW_STD(LOW_STD), .HIGH_STD(HIGH_STD),
    .LOW_FAST(LOW_FAST), .HIGH_FAST(HIGH_FAST)
  ) u_eng (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(op),
    .cmd_byte(cmd_data), .fast(cfg_fast), .bus_busy(st_busy),
    .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .ready(cmd_ready), .taken(taken), .master(st_master), .wr(wr),
    .shreg(rx_data), .done_p(done_p), .nack_p(nack_p), .arb_p(arb_p)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_eob      <= 1'b0;
      st_ack_fail <= 1'b0;
      st_arb_lost <= 1'b0;
      st_tx       <= 1'b0;
      irq         <= 1'b0;
    end else begin
      if (done_p) st_eob <= 1'b1;
      else if (status_rd || (taken && op == OP_WRITE)) st_eob <= 1'b0;
      if (nack_p) st_ack_fail <= 1'b1;
      else if (status_rd) st_ack_fail <= 1'b0;
      if (arb_p) st_arb_lost <= 1'b1;
      else if (status_rd) st_arb_lost <= 1'b0;
      if (taken && op == OP_WRITE) st_tx <= 1'b1;
      else if (taken && op == OP_READ) st_tx <= 1'b0;
      irq <= cfg_irq_en && (st_eob || st_ack_fail || st_arb_lost);
    end
  end

  // R12: the interrupt is never raised unless it was enabled
  p_irq_gate_r12: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(cfg_irq_en));
  // R11: a status read with no byte ending clears the end-of-byte flag
  p_eob_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !done_p) |=> !st_eob);
  // R1/R2: the engine never pulls SCL while in slave mode and idle
  p_slave_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!st_master && cmd_ready) |-> !scl_oe);
endmodule

// File: tb/i2cm_ctrl_test.sv
module i2cm_ctrl_test;
  localparam int LS = 12, HS = 10, LF = 5, HF = 4, STRETCH = 25;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cfg_fast = 1'b0, cfg_irq_en = 1'b1, status_rd = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'h00;
  logic cmd_ready, scl_oe, sda_oe, st_master, st_busy, st_tx, st_eob, st_ack_fail, st_arb_lost, irq;
  logic [7:0] rx_data;

  logic slv_scl_low = 1'b0, slv_sda_low = 1'b0, oth_sda_low = 1'b0;
  wire scl_bus = !(scl_oe || slv_scl_low);
  wire sda_bus = !(sda_oe || slv_sda_low || oth_sda_low);

  int checks = 0, fails = 0, cycles = 0;

  i2cm_ctrl #(.LOW_STD(LS), .HIGH_STD(HS), .LOW_FAST(LF), .HIGH_FAST(HF)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .cfg_fast(cfg_fast), .cfg_irq_en(cfg_irq_en), .status_rd(status_rd),
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data),
    .st_master(st_master), .st_busy(st_busy), .st_tx(st_tx), .st_eob(st_eob),
    .st_ack_fail(st_ack_fail), .st_arb_lost(st_arb_lost), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // slave model: counts SCL falls within one byte
  logic slv_en = 1'b0, slv_rd = 1'b0, slv_ack = 1'b1, stretch_en = 1'b0, oth_arm = 1'b0;
  logic slv_got_ack = 1'b0;
  logic [7:0] slv_byte = 8'h00;
  int fcnt = 0;

  always @(negedge scl_bus) if (slv_en) begin
    fcnt++;
    if (oth_arm && fcnt == 1) oth_sda_low = 1'b1;
    if (!slv_rd) begin
      if (fcnt == 8) slv_sda_low = slv_ack;
      else if (fcnt == 9) slv_sda_low = 1'b0;
    end else begin
      if (fcnt < 8) slv_sda_low = !slv_byte[7-fcnt];
      else slv_sda_low = 1'b0;
    end
    if (stretch_en && fcnt == 3) begin
      slv_scl_low = 1'b1;
      repeat (STRETCH) @(negedge clk);
      slv_scl_low = 1'b0;
    end
  end

  always @(posedge scl_bus) if (slv_en && slv_rd && fcnt == 8) slv_got_ack = !sda_bus;

  // run-length monitor on the SCL line
  logic mon_en = 1'b0, prev_scl = 1'b1;
  int run = 0, last_lo = 0, hi_bad = 0, exp_hi = HS;
  always @(posedge clk) begin
    if (scl_bus == prev_scl) run++;
    else begin
      if (prev_scl) begin
        if (mon_en && run != exp_hi) hi_bad++;
      end else last_lo = run;
      run = 1;
      prev_scl = scl_bus;
    end
  end

  function automatic int lo_of(input logic f); return f ? LF : LS; endfunction
  function automatic int hi_of(input logic f); return f ? HF : HS; endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready();
    int t = 0;
    while (!cmd_ready && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_status();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic ack, input logic f, input logic st);
    cfg_fast = f; exp_hi = hi_of(f);
    slv_rd = 1'b0; slv_ack = ack; fcnt = 0; stretch_en = st; hi_bad = 0;
    slv_en = 1'b1; mon_en = 1'b1;
    cmd(2'd1, b);
    wait_ready();
    mon_en = 1'b0; slv_en = 1'b0; slv_sda_low = 1'b0;
    check("R4 ack_fail", st_ack_fail, !ack);
    check("R4 bus byte", rx_data, b);
    check("R4 tx flag", st_tx, 1);
    check("R11 eob set", st_eob, 1);
    check("R6 low run", last_lo, lo_of(f));
    check(st ? "R7 high runs" : "R6 high runs", hi_bad, 0);
    check("R4 still master", st_master, 1);
    rd_status();
    check("R11 eob cleared", st_eob, 0);
    check("R11 ack_fail cleared", st_ack_fail, 0);
  endtask

  task automatic rd_byte(input logic [7:0] b, input logic ack, input logic f);
    cfg_fast = f; exp_hi = hi_of(f);
    slv_rd = 1'b1; slv_byte = b; fcnt = 0; stretch_en = 1'b0; hi_bad = 0;
    slv_sda_low = !b[7]; slv_got_ack = !ack;
    slv_en = 1'b1; mon_en = 1'b1;
    cmd(2'd2, {7'b0, ack});
    wait_ready();
    mon_en = 1'b0; slv_en = 1'b0; slv_sda_low = 1'b0;
    check("R5 rx_data", rx_data, b);
    check("R5 ack driven", slv_got_ack, ack);
    check("R5 tx flag", st_tx, 0);
    check("R11 eob set", st_eob, 1);
    check("R6 high runs", hi_bad, 0);
    check("R4 no ack_fail on read", st_ack_fail, 0);
    rd_status();
  endtask

  initial begin
    int saw;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 scl_oe", scl_oe, 0);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 master", st_master, 0);
    check("R1 busy", st_busy, 0);
    check("R1 flags", {st_eob, st_ack_fail, st_arb_lost, st_tx, irq}, 0);
    check("R1 rx_data", rx_data, 0);
    check("R1 ready", cmd_ready, 1);

    // R3: data and stop commands ignored in slave mode
    saw = 0;
    cmd(2'd1, 8'h5A);
    repeat (40) begin @(negedge clk); if (scl_oe || sda_oe) saw++; end
    cmd(2'd3, 8'h00);
    repeat (40) begin @(negedge clk); if (scl_oe || sda_oe) saw++; end
    check("R3 lines idle in slave mode", saw, 0);
    check("R3 no eob in slave mode", st_eob, 0);
    check("R3 no tx in slave mode", st_tx, 0);

    // R2 start
    cmd(2'd0, 8'h00);
    wait_ready();
    check("R2 master after start", st_master, 1);
    check("R2 SCL held low", scl_oe, 1);
    check("R10 busy after start", st_busy, 1);
    cmd(2'd0, 8'h00);
    repeat (30) @(negedge clk);
    check("R2 second start ignored", cmd_ready, 1);

    // R4/R6/R11/R12 writes
    wr_byte(8'hA7, 1'b1, 1'b0, 1'b0);
    wr_byte(8'h3C, 1'b0, 1'b0, 1'b0);
    // R12 irq with enable
    cfg_irq_en = 1'b1;
    wr_byte(8'h81, 1'b1, 1'b1, 1'b0);
    rd_byte(8'hC5, 1'b1, 1'b0);
    rd_byte(8'h5A, 1'b0, 1'b1);
    // R7 clock stretch
    wr_byte(8'h69, 1'b1, 1'b0, 1'b1);

    // R12 interrupt follows flags / enable
    cfg_fast = 1'b0; slv_rd = 1'b0; slv_ack = 1'b1; fcnt = 0; stretch_en = 1'b0; slv_en = 1'b1;
    cmd(2'd1, 8'h12);
    wait_ready();
    slv_en = 1'b0; slv_sda_low = 1'b0;
    check("R12 irq with enable", irq, 1);
    cfg_irq_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 irq masked", irq, 0);
    cfg_irq_en = 1'b1;
    // R3/R11: write clears eob; second command while busy ignored
    slv_ack = 1'b1; fcnt = 0; slv_en = 1'b1;
    cmd(2'd1, 8'hF0);
    check("R11 eob cleared by write", st_eob, 0);
    cmd(2'd1, 8'h0F);
    wait_ready();
    slv_en = 1'b0; slv_sda_low = 1'b0;
    saw = 0;
    repeat (30) begin @(negedge clk); if (!cmd_ready) saw++; end
    check("R3 command while running ignored", saw, 0);
    check("R3 first byte kept", rx_data, 8'hF0);
    rd_status();

    // random mix
    for (int i = 0; i < 24; i++) begin
      logic [7:0] b;
      logic a, f, r;
      b = 8'($urandom); a = 1'($urandom); f = 1'($urandom); r = 1'($urandom);
      if (r) rd_byte(b, a, f);
      else wr_byte(b, a, f, 1'b0);
    end

    // R8 arbitration not lost when driving low
    cfg_fast = 1'b0;
    @(negedge clk); oth_sda_low = 1'b1;
    slv_rd = 1'b0; slv_ack = 1'b1; fcnt = 0; slv_en = 1'b1;
    cmd(2'd1, 8'h00);
    wait_ready();
    slv_en = 1'b0; slv_sda_low = 1'b0;
    @(negedge clk); oth_sda_low = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 low bits never lose", st_arb_lost, 0);
    check("R8 still master", st_master, 1);
    rd_status();

    // R9 stop
    cmd(2'd3, 8'h00);
    wait_ready();
    check("R9 slave after stop", st_master, 0);
    check("R9 lines released", {scl_oe, sda_oe}, 0);
    check("R10 busy cleared by stop", st_busy, 0);

    // R8 arbitration loss
    cmd(2'd0, 8'h00);
    wait_ready();
    slv_rd = 1'b0; slv_ack = 1'b1; fcnt = 0; oth_arm = 1'b1; slv_en = 1'b1;
    cmd(2'd1, 8'hC0);
    repeat (60) @(negedge clk);
    slv_en = 1'b0; oth_arm = 1'b0; slv_sda_low = 1'b0;
    check("R8 arb_lost set", st_arb_lost, 1);
    check("R8 slave after loss", st_master, 0);
    check("R8 lines released", {scl_oe, sda_oe}, 0);
    check("R8 no eob on loss", st_eob, 0);
    check("R10 bus still busy", st_busy, 1);
    check("R12 irq on loss", irq, 1);
    @(negedge clk); oth_sda_low = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 busy cleared by other stop", st_busy, 0);
    rd_status();
    check("R11 arb_lost cleared", st_arb_lost, 0);

    // R2/R10 start refused while another master holds the bus
    @(negedge clk); oth_sda_low = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 busy on other start", st_busy, 1);
    saw = 0;
    cmd(2'd0, 8'h00);
    repeat (30) begin @(negedge clk); if (scl_oe || sda_oe) saw++; end
    check("R2 start refused while busy", saw + st_master, 0);
    @(negedge clk); oth_sda_low = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 busy cleared", st_busy, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule